// File: doc/BRIEF.md
# Clock-Stop Throttle Duty Generator

This block drives an active-low stop-clock request that a processor uses to slow itself down. The request pulses at a programmable duty within a fixed window of 2^PERIOD_LOG2 bus clocks (1024 by default). Within each window it is held low for a number of clocks set by a 3-bit duty code, then released for the rest of the window.

Two sources can ask for throttling. Software sets an enable bit and a duty code in a small control register. A thermal override input forces throttling with its own duty code, and that code may be written only once after reset. The thermal request has no enable and takes precedence over the software request. Neither source throttles unless the power-state input reports the full-run state (C0). In C2 the output stays high.

A single 8-bit control register is written through a strobe and data bus and is always visible on a readback bus. Address decoding, power-state sequencing and temperature sensing live outside the block.

Top module: `stpclk_throttle`

## Requirements
- R1: The throttle window is P = 2^PERIOD_LOG2 clocks. While throttling is continuously active, stpclk_n is low for the first N clocks of every window and high for the remaining P-N. The first low cycle is seen in the clock after the one in which throttling became active, so successive falling edges are exactly P clocks apart.
- R2: N is taken from a 3-bit duty code. Code c in 1..7 gives (8-c)*P/8 low clocks. Code 0 gives P/2, the same as code 4.
- R3: The software source requests throttling only when the enable bit (register bit 4) is 1 and in_c0 is 1, and it then uses the software duty code (register bits 3:1).
- R4: The thermal duty code (register bits 7:5) is loaded by the first register write after reset. Later writes leave it unchanged, and only reset clears it and allows it to be loaded again. Bits 4:1 are updated by every write.
- R5: The thermal source throttles whenever thermal_hot is 1 and in_c0 is 1, whatever the value of the enable bit.
- R6: When both sources request throttling, the thermal duty code sets N.
- R7: While in_c0 is 0 (C2 state), stpclk_n is high from the next clock on.
- R8: When no source requests throttling, stpclk_n is high on the next clock and the window position returns to zero. A later request therefore starts a fresh window that begins low.
- R9: rd_data returns {thermal code, enable, software code, 0}. Bit 0 always reads 0, and writes to it have no effect.
- R10: A change of duty code or of source while throttling continues takes effect at the next window boundary. The N in force is captured when a window starts.
- R11: A synchronous active-high reset sets the register to 0x00 and drives stpclk_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| thermal_hot | input | 1 | Thermal override condition active |
| in_c0 | input | 1 | 1 = C0 (run) state, 0 = C2 state |
| stpclk_n | output | 1 | Active-low stop-clock request |
| rd_data | output | 8 | Control register readback |

## Verification
The bench builds the block with PERIOD_LOG2 = 6, which gives a 64-clock window. Every duty code, every window wrap and each change of source then fits in a few thousand cycles. With this value one eighth of the window is 8 clocks, so each duty level gives a distinct low count, and a change in the middle of a window can be seen against the boundary capture. The reference model works only from P, so the mapping scales the same way as at the default of 1024.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

    localparam int DUTY_W = 3;
    localparam int REG_W  = 8;

    // register bit positions (software decodes these)
    localparam int THM_LSB = 5;
    localparam int EN_BIT  = 4;
    localparam int SW_LSB  = 1;

    typedef logic [DUTY_W-1:0] duty_code_t;

    // packed image of bits 7:1 of the control register
    typedef struct packed {
        duty_code_t thm;
        logic       en;
        duty_code_t sw;
    } ctrl_reg_t;

    typedef struct packed {
        logic       active;
        duty_code_t code;
    } throttle_req_t;

    // low time in eighths of the window; code 0 aliases to half
    function automatic logic [2:0] duty_eighths(input duty_code_t code);
        logic [3:0] m;
        if (code == '0) m = 4'd4;
        else            m = 4'd8 - {1'b0, code};
        return m[2:0];
    endfunction

endpackage

// File: rtl/throttle_ctrl_reg.sv
module throttle_ctrl_reg
    import throttle_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [REG_W-1:1] wr_bits,
    output ctrl_reg_t  ctrl
);

    ctrl_reg_t ctrl_q;
    logic      thm_locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            thm_locked_q <= 1'b0;
        end else if (wr_en) begin
            ctrl_q.en    <= wr_bits[EN_BIT];
            ctrl_q.sw    <= wr_bits[SW_LSB +: DUTY_W];
            thm_locked_q <= 1'b1;
            if (!thm_locked_q)
                ctrl_q.thm <= wr_bits[THM_LSB +: DUTY_W];
        end
    end

    assign ctrl = ctrl_q;

    // R4: once locked, the thermal field must not move on a write
    assert_thm_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (thm_locked_q && wr_en) |=> $stable(ctrl_q.thm));

    // R4: any write arms the lock
    assert_lock_arms_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> thm_locked_q);

endmodule

// File: rtl/throttle_source_sel.sv
module throttle_source_sel
    import throttle_pkg::*;
(
    input  ctrl_reg_t     ctrl,
    input  logic          thermal_hot,
    input  logic          in_c0,
    output throttle_req_t req
);

    logic sw_want;
    logic thm_want;

    always_comb begin
        sw_want    = ctrl.en && in_c0;
        thm_want   = thermal_hot && in_c0;
        req.active = sw_want || thm_want;
        if (thm_want)
            req.code = ctrl.thm;
        else
            req.code = ctrl.sw;
    end

endmodule

// File: rtl/throttle_period_gen.sv
module throttle_period_gen
    import throttle_pkg::*;
#(
    parameter int PERIOD_LOG2 = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  throttle_req_t req,
    output logic          stpclk_n
);

    localparam int PW      = PERIOD_LOG2;
    localparam int FRAC_SH = PW - 3;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit_q;
    logic [PW-1:0] new_limit;
    logic [PW-1:0] eff_limit;
    logic          stp_q;
    logic          at_start;

    always_comb begin
        new_limit = {duty_eighths(req.code), {FRAC_SH{1'b0}}};
        at_start  = (cnt_q == '0);
        eff_limit = at_start ? new_limit : limit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            limit_q <= '0;
            stp_q   <= 1'b1;
        end else if (!req.active) begin
            cnt_q <= '0;
            stp_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + PW'(1);
            if (at_start)
                limit_q <= new_limit;
            stp_q <= !(cnt_q < eff_limit);
        end
    end

    assign stpclk_n = stp_q;

    // R8: no request means a released output next cycle
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        !req.active |=> stp_q);

    // R1: every window opens with an asserted cycle
    assert_window_starts_low_R1: assert property (@(posedge clk) disable iff (rst)
        (req.active && at_start) |=> !stp_q);

    // R1: once released inside a window, stays released until the wrap
    assert_no_reassert_R1: assert property (@(posedge clk) disable iff (rst)
        (req.active && !at_start && stp_q) |=> stp_q);

endmodule

// File: rtl/stpclk_throttle.sv
module stpclk_throttle
    import throttle_pkg::*;
#(
    parameter int PERIOD_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             thermal_hot,
    input  logic             in_c0,
    output logic             stpclk_n,
    output logic [REG_W-1:0] rd_data
);

    ctrl_reg_t     ctrl;
    throttle_req_t req;
    logic          unused_rsvd_bit;

    assign unused_rsvd_bit = wr_data[0];

    throttle_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bits (wr_data[REG_W-1:1]),
        .ctrl    (ctrl)
    );

    throttle_source_sel u_sel (
        .ctrl        (ctrl),
        .thermal_hot (thermal_hot),
        .in_c0       (in_c0),
        .req         (req)
    );

    throttle_period_gen #(
        .PERIOD_LOG2 (PERIOD_LOG2)
    ) u_gen (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .stpclk_n (stpclk_n)
    );

    assign rd_data = {ctrl, 1'b0};

    // R7: C2 state never throttles
    assert_c2_released_R7: assert property (@(posedge clk) disable iff (rst)
        !in_c0 |=> stpclk_n);

    // R11: reset leaves the output released
    assert_reset_released_R11: assert property (@(posedge clk)
        rst |=> stpclk_n);

endmodule

// File: tb/stpclk_throttle_tb.sv
module stpclk_throttle_tb;

    localparam int PL = 6;
    localparam int P  = 1 << PL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       thermal_hot = 1'b0;
    logic       in_c0 = 1'b1;
    logic       stpclk_n;
    logic [7:0] rd_data;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R11";
    bit    done = 0;

    // reference model state
    int  m_thm = 0, m_en = 0, m_sw = 0, m_lock = 0;
    int  m_cnt = 0, m_lim = 0;
    bit  m_stp = 1;

    always #10 clk = ~clk;

    stpclk_throttle #(.PERIOD_LOG2(PL)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .thermal_hot(thermal_hot), .in_c0(in_c0),
        .stpclk_n(stpclk_n), .rd_data(rd_data)
    );

    function automatic int lows_for(input int code);
        return ((code == 0) ? 4 : (8 - code)) * (P / 8);
    endfunction

    // behavioural model, advances on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_thm = 0; m_en = 0; m_sw = 0; m_lock = 0;
            m_cnt = 0; m_lim = 0; m_stp = 1;
        end else begin
            bit act;
            int code;
            act  = in_c0 && (thermal_hot || (m_en != 0));
            code = thermal_hot ? m_thm : m_sw;
            if (!act) begin
                m_cnt = 0; m_stp = 1;
            end else begin
                if (m_cnt == 0) m_lim = lows_for(code);
                m_stp = (m_cnt < m_lim) ? 1'b0 : 1'b1;
                m_cnt = (m_cnt + 1) % P;
            end
            if (wr_en) begin
                if (m_lock == 0) begin m_thm = wr_data[7:5]; m_lock = 1; end
                m_en = wr_data[4];
                m_sw = wr_data[3:1];
            end
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #5;
        if (!done) begin
            logic [7:0] exp_rd;
            exp_rd = {m_thm[2:0], m_en[0], m_sw[2:0], 1'b0};
            n_vec++;
            if (stpclk_n !== m_stp || rd_data !== exp_rd) begin
                n_bad++;
                $display("FAIL %s: stpclk_n=%0b rd=%02h expected stpclk_n=%0b rd=%02h at %0t",
                         cur_req, stpclk_n, rd_data, m_stp, exp_rd, $time);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // count low cycles across n following samples
    task automatic count_lows(input int n, output int lows);
        lows = 0;
        repeat (n) begin
            @(posedge clk); #5;
            if (!stpclk_n) lows++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int lows;
        int t0;
        int t1;
        cycles(3);
        rst = 1'b0;
        @(posedge clk); #5;
        check("R11", rd_data, 0);
        check("R11", stpclk_n, 1);

        // reserved bit only; also consumes the thermal write
        cur_req = "R9";
        wr(8'h01);
        @(posedge clk); #5;
        check("R9", rd_data, 0);

        cur_req = "R4";
        wr(8'hE0);
        @(posedge clk); #5;
        check("R4", rd_data[7:5], 0);

        // thermal with code 0 while enable is 0: half window
        cur_req = "R5";
        @(negedge clk); thermal_hot = 1'b1;
        cycles(2);
        count_lows(P, lows);
        check("R5", lows, P / 2);

        cur_req = "R7";
        @(negedge clk); in_c0 = 1'b0;
        count_lows(P, lows);
        check("R7", lows, 0);
        @(negedge clk); thermal_hot = 1'b0; in_c0 = 1'b1;

        // fresh reset re-arms the thermal field
        cur_req = "R11";
        do_reset();
        cur_req = "R4";
        wr(8'hC0);
        wr(8'h20);
        @(posedge clk); #5;
        check("R4", rd_data[7:5], 6);

        // every software duty code
        cur_req = "R2";
        for (int c = 0; c < 8; c++) begin
            wr({3'b000, 1'b0, 3'(c), 1'b0});
            wr({3'b000, 1'b1, 3'(c), 1'b0});
            cycles(2);
            count_lows(P, lows);
            check("R2", lows, lows_for(c));
        end

        cur_req = "R3";
        @(negedge clk); in_c0 = 1'b0;
        cycles(1);
        count_lows(P, lows);
        check("R3", lows, 0);
        @(negedge clk); in_c0 = 1'b1;
        wr(8'h0E);
        cycles(1);
        count_lows(P, lows);
        check("R3", lows, 0);

        // both sources: thermal code 6 wins over software code 7
        cur_req = "R6";
        wr(8'h1E);
        @(negedge clk); thermal_hot = 1'b1;
        cycles(P + 2);
        count_lows(P, lows);
        check("R6", lows, lows_for(6));

        // drop thermal mid-window; new duty waits for the boundary
        cur_req = "R10";
        cycles(P / 4);
        @(negedge clk); thermal_hot = 1'b0;
        cycles(2 * P);
        count_lows(P, lows);
        check("R10", lows, lows_for(7));

        // window spacing: two falling edges P apart
        cur_req = "R1";
        do begin @(posedge clk); #5; end while (stpclk_n);
        t0 = 0;
        do begin @(posedge clk); #5; t0++; end while (!stpclk_n);
        do begin @(posedge clk); #5; t0++; end while (stpclk_n);
        check("R1", t0, P);

        // stop mid-window and restart: fresh window, begins low
        cur_req = "R8";
        cycles(P / 4);
        wr(8'h0E);
        @(posedge clk); #5;
        check("R8", stpclk_n, 1);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h1E;
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #5;
        check("R8", stpclk_n, 0);
        t1 = 1;
        count_lows(P - 1, lows);
        check("R8", lows + t1, lows_for(7));

        cycles(4);
        finish_run();
    end

endmodule